// File: doc/BRIEF.md
# Joystick Memory Browser and Byte Editor

This block lets a user inspect and change a small on-chip byte memory with three joystick inputs: up, down and enter. In browse mode, up and down move a current address, and that address is shown as two hexadecimal digits on seven-segment patterns. The byte stored at the current address is shown in binary on eight LEDs. Enter opens an edit session on the byte at the current address. In edit mode the same up and down inputs step a working copy of the byte instead of the address. A second enter writes the working copy back to the memory and returns the block to browse mode.

The joystick inputs must already be synchronized and debounced. Each press acts once, on the first clock where the input is high after being low. The block holds the memory, the two-mode control, the address and working-value counters, and the hexadecimal-to-segment decoding. Digit multiplexing is not part of this block.

Top module: `joy_mem_editor`

## Requirements
- R1: With the synchronous active-high `rst` asserted, the block enters browse mode at address 00 on the next clock. The memory powers up with every byte 00.
- R2: In browse mode, an up press adds one to the address and a down press subtracts one. Both wrap modulo 256 (FF+1 gives 00, 00-1 gives FF).
- R3: `addrSegs[13:7]` shows the high nibble of the current address and `addrSegs[6:0]` shows the low nibble. Bit i of each digit lights segment a..g for i = 0..6, active high. The digit codes 0..F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R4: In browse mode, `leds` shows the byte stored at the current address, with bit 7 as the MSB.
- R5: An enter press in browse mode switches to edit mode. It also loads the working value with the stored byte, and from then on `leds` shows the working value.
- R6: In edit mode, up adds one to the working value and down subtracts one, wrapping modulo 256. The address does not change.
- R7: An enter press in edit mode writes the working value to the current address and returns to browse mode. The written byte appears on `leds` in the cycle after the press.
- R8: Each input acts only on the clock where it is high and was low on the previous clock. Holding an input high causes no further steps.
- R9: Up and down pressed in the same cycle without enter have no effect. When enter is pressed together with up or down, only enter acts.
- R10: Reset does not change the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btnUp | input | 1 | Joystick up, synchronized and debounced |
| btnDown | input | 1 | Joystick down, synchronized and debounced |
| btnEnter | input | 1 | Joystick enter, synchronized and debounced |
| leds | output | 8 | Stored byte (browse) or working value (edit) |
| addrSegs | output | 14 | Two seven-segment patterns for the current address |

## Verification
A wrong address register shows on the segment patterns in the same cycle and on the LEDs, because the LEDs then read the wrong location. A wrong mode shows on the very next press, as an address step where a data step was expected or the reverse. A lost or misplaced write stays hidden until the edited address is browsed again. For that reason every one of the 256 locations is written with a distinct value and then read back after the address has wrapped.

// File: rtl/joy_mem_pkg.sv
package joy_mem_pkg;

  typedef enum logic {
    MODE_BROWSE = 1'b0,
    MODE_EDIT   = 1'b1
  } editMode_t;

  // Single-cycle strobes from control to datapath.
  typedef struct packed {
    logic addrInc;
    logic addrDec;
    logic loadWork;
    logic workInc;
    logic workDec;
    logic commit;
    logic showWork;
  } ctrlStrobes_t;

endpackage

// File: rtl/joy_hex_seg.sv
module joy_hex_seg (
  input  logic [3:0] nibble,
  output logic [6:0] seg
);
  // seg[0] = a ... seg[6] = g, active high
  always_comb begin
    case (nibble)
      4'h0: seg = 7'h3F;
      4'h1: seg = 7'h06;
      4'h2: seg = 7'h5B;
      4'h3: seg = 7'h4F;
      4'h4: seg = 7'h66;
      4'h5: seg = 7'h6D;
      4'h6: seg = 7'h7D;
      4'h7: seg = 7'h07;
      4'h8: seg = 7'h7F;
      4'h9: seg = 7'h6F;
      4'hA: seg = 7'h77;
      4'hB: seg = 7'h7C;
      4'hC: seg = 7'h39;
      4'hD: seg = 7'h5E;
      4'hE: seg = 7'h79;
      default: seg = 7'h71;
    endcase
  end
endmodule

// File: rtl/joy_mem_ctrl.sv
module joy_mem_ctrl
  import joy_mem_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         btnUp,
  input  logic         btnDown,
  input  logic         btnEnter,
  output ctrlStrobes_t strobes,
  output logic         inEdit
);
  logic [2:0] btnNow;
  logic [2:0] btnPrev;
  logic [2:0] btnRise;
  editMode_t  mode;
  editMode_t  modeNext;

  assign btnNow = {btnEnter, btnDown, btnUp};

  // Previous-cycle sample for rising-edge detection (tracks inputs in reset too).
  always_ff @(posedge clk) begin
    btnPrev <= btnNow;
  end

  assign btnRise = btnNow & ~btnPrev;

  logic upHit, downHit, enterHit;
  assign upHit    = btnRise[0] & ~btnRise[1];
  assign downHit  = btnRise[1] & ~btnRise[0];
  assign enterHit = btnRise[2];

  always_comb begin
    strobes  = '0;
    modeNext = mode;
    unique case (mode)
      MODE_BROWSE: begin
        if (enterHit) begin
          strobes.loadWork = 1'b1;
          modeNext         = MODE_EDIT;
        end else if (upHit) begin
          strobes.addrInc = 1'b1;
        end else if (downHit) begin
          strobes.addrDec = 1'b1;
        end
      end
      MODE_EDIT: begin
        if (enterHit) begin
          strobes.commit = 1'b1;
          modeNext       = MODE_BROWSE;
        end else if (upHit) begin
          strobes.workInc = 1'b1;
        end else if (downHit) begin
          strobes.workDec = 1'b1;
        end
      end
      default: modeNext = MODE_BROWSE;
    endcase
    strobes.showWork = (mode == MODE_EDIT);
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= MODE_BROWSE;
    else     mode <= modeNext;
  end

  assign inEdit = (mode == MODE_EDIT);
endmodule

// File: rtl/joy_mem_datapath.sv
module joy_mem_datapath
  import joy_mem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int DIGITS = (ADDR_W + 3) / 4,
  localparam int SEG_W  = DIGITS * 7
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] workQ,
  output logic [DATA_W-1:0] ledOut,
  output logic [SEG_W-1:0]  segOut
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAD_W = DIGITS * 4;
  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
  localparam logic [DATA_W-1:0] DATA_ONE = 1;

  logic [DATA_W-1:0] memArray [DEPTH];
  logic [DATA_W-1:0] readData;

  // Power-up contents are all zero; reset leaves the array untouched.
  initial begin
    for (int i = 0; i < DEPTH; i++) memArray[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (strobes.commit) memArray[addrQ] <= workQ;
  end

  assign readData = memArray[addrQ];

  always_ff @(posedge clk) begin
    if (rst)                  addrQ <= '0;
    else if (strobes.addrInc) addrQ <= addrQ + ADDR_ONE;
    else if (strobes.addrDec) addrQ <= addrQ - ADDR_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)                   workQ <= '0;
    else if (strobes.loadWork) workQ <= readData;
    else if (strobes.workInc)  workQ <= workQ + DATA_ONE;
    else if (strobes.workDec)  workQ <= workQ - DATA_ONE;
  end

  assign ledOut = strobes.showWork ? workQ : readData;

  logic [PAD_W-1:0] addrPad;
  assign addrPad = PAD_W'(addrQ);

  for (genvar d = 0; d < DIGITS; d++) begin : gen_digit
    joy_hex_seg hex_i (
      .nibble(addrPad[d*4 +: 4]),
      .seg   (segOut[d*7 +: 7])
    );
  end
endmodule

// File: rtl/joy_mem_editor.sv
module joy_mem_editor
  import joy_mem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int SEG_W = ((ADDR_W + 3) / 4) * 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              btnUp,
  input  logic              btnDown,
  input  logic              btnEnter,
  output logic [DATA_W-1:0] leds,
  output logic [SEG_W-1:0]  addrSegs
);
  ctrlStrobes_t      strobes;
  logic              inEdit;
  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] workVal;

  joy_mem_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .btnUp   (btnUp),
    .btnDown (btnDown),
    .btnEnter(btnEnter),
    .strobes (strobes),
    .inEdit  (inEdit)
  );

  joy_mem_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .addrQ  (curAddr),
    .workQ  (workVal),
    .ledOut (leds),
    .segOut (addrSegs)
  );
endmodule

// File: rtl/joy_mem_chk.sv
module joy_mem_chk
  import joy_mem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input ctrlStrobes_t      strobes,
  input logic              inEdit,
  input logic [ADDR_W-1:0] curAddr,
  input logic [DATA_W-1:0] workVal,
  input logic [DATA_W-1:0] leds
);
  localparam logic [ADDR_W-1:0] A1 = 1;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (curAddr == '0 && !inEdit));

  assert_addr_inc_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.addrInc |=> curAddr == $past(curAddr) + A1);

  assert_addr_dec_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.addrDec |=> curAddr == $past(curAddr) - A1);

  assert_load_shows_stored_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.loadWork |=> (inEdit && leds == $past(leds)));

  assert_edit_leds_work_R5: assert property (@(posedge clk) disable iff (rst)
    inEdit |-> leds == workVal);

  assert_addr_frozen_edit_R6: assert property (@(posedge clk) disable iff (rst)
    inEdit |=> curAddr == $past(curAddr));

  assert_commit_visible_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.commit |=> (!inEdit && leds == $past(workVal)));

  assert_single_action_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.addrInc, strobes.addrDec, strobes.loadWork,
              strobes.workInc, strobes.workDec, strobes.commit}));
endmodule

bind joy_mem_editor joy_mem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .strobes(strobes),
  .inEdit (inEdit),
  .curAddr(curAddr),
  .workVal(workVal),
  .leds   (leds)
);

// File: tb/joy_mem_editor_tb.sv
`timescale 1ns/1ps
module joy_mem_editor_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btnUp = 1'b0, btnDown = 1'b0, btnEnter = 1'b0;
  logic [7:0]  leds;
  logic [13:0] addrSegs;

  int checks = 0;
  int errors = 0;

  logic [7:0] refMem [256];
  logic [7:0] refAddr = 8'h00;
  logic [7:0] refWork = 8'h00;
  bit         refEdit = 1'b0;

  always #4 clk = ~clk;

  joy_mem_editor dut_i (
    .clk(clk), .rst(rst), .btnUp(btnUp), .btnDown(btnDown),
    .btnEnter(btnEnter), .leds(leds), .addrSegs(addrSegs)
  );

  function automatic logic [6:0] segCode(input logic [3:0] n);
    case (n)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string segReq, input string ledReq);
    check(segReq, {2'b0, addrSegs}, {2'b0, segCode(refAddr[7:4]), segCode(refAddr[3:0])});
    check(ledReq, {8'h0, leds}, {8'h0, refEdit ? refWork : refMem[refAddr]});
  endtask

  // One press: high for one cycle, low for the next; the model follows the rules.
  task automatic press(input bit u, input bit d, input bit e);
    @(negedge clk);
    btnUp = u; btnDown = d; btnEnter = e;
    @(negedge clk);
    btnUp = 0; btnDown = 0; btnEnter = 0;
    if (e) begin
      if (refEdit) begin refMem[refAddr] = refWork; refEdit = 0; end
      else begin refWork = refMem[refAddr]; refEdit = 1; end
    end else if (u && !d) begin
      if (refEdit) refWork = refWork + 8'd1; else refAddr = refAddr + 8'd1;
    end else if (d && !u) begin
      if (refEdit) refWork = refWork - 8'd1; else refAddr = refAddr - 8'd1;
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    refAddr = 8'h00; refEdit = 0; refWork = 8'h00;
  endtask

  initial begin
    #(8ns * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) refMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    checkAll("R1 reset address", "R1 reset zero memory");

    // R2: wrap in both directions
    press(0, 1, 0); checkAll("R2 down wrap 00->FF", "R4 browse led");
    press(1, 0, 0); checkAll("R2 up wrap FF->00", "R4 browse led");

    // Sweep: give each location a distinct value via edit
    for (int a = 0; a < 256; a++) begin
      press(0, 0, 1); checkAll("R6 addr held on entry", "R5 load stored byte");
      for (int k = 0; k < (a % 5) + 1; k++) begin
        if (a % 2 == 0) press(1, 0, 0); else press(0, 1, 0);
        checkAll("R6 addr frozen in edit", "R6 working value step");
      end
      press(0, 0, 1); checkAll("R7 addr after commit", "R7 committed byte shown");
      press(1, 0, 0); checkAll("R2 step to next address", "R4 browse led");
    end

    // Read-back after address wrap: all segments and all bytes (R3, R4)
    for (int a = 0; a < 256; a++) begin
      checkAll("R3 segment pattern", "R4 stored byte");
      press(1, 0, 0);
    end

    // R6: data wrap FF -> 00 in edit mode
    press(0, 0, 1);
    while (refWork != 8'hFF) press(0, 1, 0);
    checkAll("R6 addr frozen", "R6 reached FF");
    press(1, 0, 0); checkAll("R6 addr frozen", "R6 wrap FF->00");
    press(0, 0, 1); checkAll("R7 addr", "R7 commit of wrapped value");

    // R8: held input steps once
    @(negedge clk); btnUp = 1;
    repeat (5) @(negedge clk);
    refAddr = refAddr + 8'd1;
    checkAll("R8 hold steps once", "R8 led after hold");
    btnUp = 0; @(negedge clk);
    checkAll("R8 release no step", "R8 led after release");

    // R9: up and down together do nothing
    press(1, 1, 0); checkAll("R9 up+down no addr change", "R9 up+down led");
    press(0, 0, 1);
    press(1, 1, 0); checkAll("R9 up+down addr in edit", "R9 up+down no data change");
    press(0, 0, 1);
    // R9: enter with up in browse: only enter acts
    press(1, 0, 1); checkAll("R9 enter+up addr unchanged", "R9 enter+up loads work");
    press(1, 0, 0); press(1, 0, 0);
    press(0, 1, 1); checkAll("R9 enter+down addr", "R9 enter+down commits unchanged");

    // R10: reset preserves memory
    doReset();
    checkAll("R1 address back to 00", "R10 memory kept over reset");
    for (int a = 0; a < 8; a++) begin
      press(0, 1, 0); checkAll("R2 down after reset", "R10 memory kept over reset");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule